// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers 64 raw interrupt lines, held in two banks of 32, and turns them into three interrupt outputs. Each line first passes a two-flop synchroniser. It then goes through a trigger-conditioning stage that all three outputs share. Software picks one of four trigger behaviours per line with two configuration bits. In the two edge modes, an event is held in a latch until software acknowledges it. In the two level modes, the conditioned value follows the pin.

Each output controller has its own enable mask and software-force mask, both changed through set and clear registers. A controller reports a raw view (conditioned line OR forced bit) and a status view (raw AND enabled). Its output is a registered OR of every status bit in both banks. Software reaches all registers through a plain 32-bit read/write port. Writes take effect at the clock edge, and reads return data combinationally from the address.

Top module: `intcTrigger`

## Requirements
- R1: After reset, all enables, soft-force bits, trigger configuration bits and edge latches are zero, and every interrupt output is low.
- R2: The three output controllers decode at byte addresses 0x000, 0x100 and 0x300, and the trigger unit decodes at 0x200. A controller's second bank (lines 32..63) sits 0x18 above its first. The trigger unit's second bank sits 0x20 above its first. A read of any offset not listed here returns zero.
- R3: Each line's trigger comes from its rise-config bit r and fall-config bit f: (r,f)=(0,0) is active-high level, (1,1) is active-low level, (1,0) is rising edge and (0,1) is falling edge.
- R4: Each input passes two flops. A level change applied before clock edge n is not yet visible in the trigger unit status after edge n, and is visible after edge n+1.
- R5: In an edge mode, a matching transition sets a latch that stays set after the input returns. The latch reads back at trigger-unit offset 0x04. Writing 1 to a bit at that offset clears that latch, and bits written 0 keep their value.
- R6: If an edge is detected in the same cycle as the acknowledge write for that line, the latch stays set.
- R7: Level modes never set a latch: offset 0x04 reads zero for such lines, and the conditioned value drops when the input deasserts. Moving a latched line into a level mode clears its latch.
- R8: In a controller, writing 1s at 0x08 sets enable bits and writing 1s at 0x0C clears them. Reads at both offsets return the enable mask. Offsets 0x10 and 0x14 set and clear soft-force bits in the same way. Bits written 0 are left unchanged.
- R9: A controller's raw status (0x04) is the conditioned line OR its soft-force bit. Its status (0x00) is raw AND enable. The trigger unit status (0x00) is the conditioned line itself.
- R10: Output k goes high one cycle after any status bit of controller k, in either bank, is set. It goes low one cycle after all of them clear.
- R11: Trigger-unit offsets 0x08 and 0x0C write and read the whole rise and fall config words. Writing 1s at 0x10 and 0x14 sets and clears rise bits, and writing 1s at 0x18 and 0x1C sets and clears fall bits. Bits written 0 are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 64 | Raw interrupt lines, bit i is line i |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 10 | Byte address of register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| irqOut | output | 3 | One interrupt output per controller |

## Verification
The hardest case to reach from the ports is an acknowledge landing in exactly the same cycle as a fresh edge on the same line. The bench counts the two synchroniser stages and the detection register. It raises the input on one falling clock edge and issues the acknowledge write two edges later. The latch must then survive. Random stimulus changes modes, masks and inputs between settling periods. This exercises the mode switches that must clear a latch, and the lines where soft force and a live level combine.

// File: rtl/icPkg.sv
package icPkg;
  localparam int BANK_W   = 32;
  localparam int NBANK    = 2;
  localparam int NSRC     = BANK_W * NBANK;
  localparam int NCTRL    = 3;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int CIDX_W   = $clog2(NCTRL);
  localparam int BIDX_W   = $clog2(NBANK);

  // address pages (addr[9:8]) of the controllers and of the trigger unit
  localparam int CTRL_PAGE [NCTRL] = '{0, 1, 3};
  localparam int TRIG_PAGE = 2;
  localparam int CTRL_STRIDE = 'h18;
  localparam int TRIG_STRIDE = 'h20;

  // controller register offsets
  localparam int C_STAT    = 'h00;
  localparam int C_RAW     = 'h04;
  localparam int C_EN_SET  = 'h08;
  localparam int C_EN_CLR  = 'h0C;
  localparam int C_FRC_SET = 'h10;
  localparam int C_FRC_CLR = 'h14;

  // trigger unit register offsets
  localparam int T_STAT    = 'h00;
  localparam int T_LATCH   = 'h04;
  localparam int T_RISE    = 'h08;
  localparam int T_FALL    = 'h0C;
  localparam int T_RISE_S  = 'h10;
  localparam int T_RISE_C  = 'h14;
  localparam int T_FALL_S  = 'h18;
  localparam int T_FALL_C  = 'h1C;

  typedef enum logic [3:0] {
    RD_NONE, RD_C_STAT, RD_C_RAW, RD_C_EN, RD_C_FRC,
    RD_T_STAT, RD_T_LATCH, RD_T_RISE, RD_T_FALL
  } rdKindT;

  typedef struct packed {
    rdKindT            kind;
    logic [CIDX_W-1:0] ctrl;
    logic [BIDX_W-1:0] bank;
  } rdSelT;

  typedef struct packed {
    logic [NCTRL-1:0][NBANK-1:0] enSet;
    logic [NCTRL-1:0][NBANK-1:0] enClr;
    logic [NCTRL-1:0][NBANK-1:0] frcSet;
    logic [NCTRL-1:0][NBANK-1:0] frcClr;
    logic [NBANK-1:0] ack;
    logic [NBANK-1:0] riseWr;
    logic [NBANK-1:0] fallWr;
    logic [NBANK-1:0] riseSet;
    logic [NBANK-1:0] riseClr;
    logic [NBANK-1:0] fallSet;
    logic [NBANK-1:0] fallClr;
  } strobeT;
endpackage

// File: rtl/icDecode.sv
module icDecode import icPkg::*; #(
  parameter int AW = ADDR_W
) (
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  output strobeT        strb,
  output rdSelT         rdSel
);
  int page;
  int offI;

  always_comb begin
    strb       = '0;
    rdSel      = '0;
    rdSel.kind = RD_NONE;
    page = int'(regAddr[AW-1:AW-2]);
    offI = int'(regAddr[AW-3:0]);
    if (page == TRIG_PAGE) begin
      for (int b = 0; b < NBANK; b++) begin
        if (offI >= b * TRIG_STRIDE && offI < (b + 1) * TRIG_STRIDE) begin
          rdSel.bank = BIDX_W'(b);
          case (offI - b * TRIG_STRIDE)
            T_STAT:   rdSel.kind = RD_T_STAT;
            T_LATCH:  begin rdSel.kind = RD_T_LATCH; strb.ack[b]     = regWe; end
            T_RISE:   begin rdSel.kind = RD_T_RISE;  strb.riseWr[b]  = regWe; end
            T_FALL:   begin rdSel.kind = RD_T_FALL;  strb.fallWr[b]  = regWe; end
            T_RISE_S: begin rdSel.kind = RD_T_RISE;  strb.riseSet[b] = regWe; end
            T_RISE_C: begin rdSel.kind = RD_T_RISE;  strb.riseClr[b] = regWe; end
            T_FALL_S: begin rdSel.kind = RD_T_FALL;  strb.fallSet[b] = regWe; end
            T_FALL_C: begin rdSel.kind = RD_T_FALL;  strb.fallClr[b] = regWe; end
            default:  rdSel.kind = RD_NONE;
          endcase
        end
      end
    end else begin
      for (int c = 0; c < NCTRL; c++) begin
        if (page == CTRL_PAGE[c]) begin
          rdSel.ctrl = CIDX_W'(c);
          for (int b = 0; b < NBANK; b++) begin
            if (offI >= b * CTRL_STRIDE && offI < (b + 1) * CTRL_STRIDE) begin
              rdSel.bank = BIDX_W'(b);
              case (offI - b * CTRL_STRIDE)
                C_STAT:    rdSel.kind = RD_C_STAT;
                C_RAW:     rdSel.kind = RD_C_RAW;
                C_EN_SET:  begin rdSel.kind = RD_C_EN;  strb.enSet[c][b]  = regWe; end
                C_EN_CLR:  begin rdSel.kind = RD_C_EN;  strb.enClr[c][b]  = regWe; end
                C_FRC_SET: begin rdSel.kind = RD_C_FRC; strb.frcSet[c][b] = regWe; end
                C_FRC_CLR: begin rdSel.kind = RD_C_FRC; strb.frcClr[c][b] = regWe; end
                default:   rdSel.kind = RD_NONE;
              endcase
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/icTrigBank.sv
module icTrigBank #(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [BW-1:0] rawIn,
  input  logic [BW-1:0] wdata,
  input  logic          ack,
  input  logic          riseWr,
  input  logic          fallWr,
  input  logic          riseSet,
  input  logic          riseClr,
  input  logic          fallSet,
  input  logic          fallClr,
  output logic [BW-1:0] cond,
  output logic [BW-1:0] latched,
  output logic [BW-1:0] riseCfg,
  output logic [BW-1:0] fallCfg
);
  logic [BW-1:0] syncA, syncB, prevB;
  logic [BW-1:0] riseNext, fallNext, latch, latchNext;
  logic [BW-1:0] evt, lvl, ackMask;

  always_comb begin
    riseNext = riseWr ? wdata : riseCfg;
    if (riseSet) riseNext = riseNext | wdata;
    if (riseClr) riseNext = riseNext & ~wdata;
    fallNext = fallWr ? wdata : fallCfg;
    if (fallSet) fallNext = fallNext | wdata;
    if (fallClr) fallNext = fallNext & ~wdata;

    // rising code (1,0) or falling code (0,1)
    evt = (riseCfg & ~fallCfg & syncB & ~prevB) |
          (~riseCfg & fallCfg & ~syncB & prevB);
    lvl = (~riseCfg & ~fallCfg & syncB) | (riseCfg & fallCfg & ~syncB);
    ackMask = ack ? wdata : '0;
    // a new event wins over its acknowledge; a level code drops the latch
    latchNext = (evt | (latch & ~ackMask)) & (riseNext ^ fallNext);
    cond = lvl | latch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevB   <= '0;
      riseCfg <= '0;
      fallCfg <= '0;
      latch   <= '0;
    end else begin
      syncA   <= rawIn;
      syncB   <= syncA;
      prevB   <= syncB;
      riseCfg <= riseNext;
      fallCfg <= fallNext;
      latch   <= latchNext;
    end
  end

  assign latched = latch;
endmodule

// File: rtl/icCore.sv
module icCore import icPkg::*; #(
  parameter int BW = BANK_W,
  parameter int NB = NBANK,
  parameter int NC = NCTRL,
  parameter int DW = DATA_W,
  localparam int NS = BW * NB
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NS-1:0]         irqIn,
  input  strobeT                strb,
  input  rdSelT                 rdSel,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic [NC-1:0][NS-1:0] ctrlStatus
);
  logic [BW-1:0] condB [NB];
  logic [BW-1:0] latB  [NB];
  logic [BW-1:0] riseB [NB];
  logic [BW-1:0] fallB [NB];

  logic [NC-1:0][NB-1:0][BW-1:0] en, enNext, frc, frcNext, rawV, statV;

  for (genvar b = 0; b < NB; b++) begin : gBank
    icTrigBank #(.BW(BW)) uTrig (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (irqIn[b*BW +: BW]),
      .wdata   (wdata[BW-1:0]),
      .ack     (strb.ack[b]),
      .riseWr  (strb.riseWr[b]),
      .fallWr  (strb.fallWr[b]),
      .riseSet (strb.riseSet[b]),
      .riseClr (strb.riseClr[b]),
      .fallSet (strb.fallSet[b]),
      .fallClr (strb.fallClr[b]),
      .cond    (condB[b]),
      .latched (latB[b]),
      .riseCfg (riseB[b]),
      .fallCfg (fallB[b])
    );
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < NB; b++) begin
        enNext[c][b] = en[c][b];
        if (strb.enSet[c][b]) enNext[c][b] = enNext[c][b] | wdata[BW-1:0];
        if (strb.enClr[c][b]) enNext[c][b] = enNext[c][b] & ~wdata[BW-1:0];
        frcNext[c][b] = frc[c][b];
        if (strb.frcSet[c][b]) frcNext[c][b] = frcNext[c][b] | wdata[BW-1:0];
        if (strb.frcClr[c][b]) frcNext[c][b] = frcNext[c][b] & ~wdata[BW-1:0];
        rawV[c][b]  = condB[b] | frc[c][b];
        statV[c][b] = rawV[c][b] & en[c][b];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en  <= '0;
      frc <= '0;
    end else begin
      en  <= enNext;
      frc <= frcNext;
    end
  end

  assign ctrlStatus = statV;

  always_comb begin
    rdata = '0;
    case (rdSel.kind)
      RD_C_STAT:  rdata[BW-1:0] = statV[rdSel.ctrl][rdSel.bank];
      RD_C_RAW:   rdata[BW-1:0] = rawV[rdSel.ctrl][rdSel.bank];
      RD_C_EN:    rdata[BW-1:0] = en[rdSel.ctrl][rdSel.bank];
      RD_C_FRC:   rdata[BW-1:0] = frc[rdSel.ctrl][rdSel.bank];
      RD_T_STAT:  rdata[BW-1:0] = condB[rdSel.bank];
      RD_T_LATCH: rdata[BW-1:0] = latB[rdSel.bank];
      RD_T_RISE:  rdata[BW-1:0] = riseB[rdSel.bank];
      RD_T_FALL:  rdata[BW-1:0] = fallB[rdSel.bank];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/intcTrigger.sv
module intcTrigger import icPkg::*; #(
  parameter int BW = BANK_W,
  parameter int NB = NBANK,
  parameter int NC = NCTRL,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int NS = BW * NB
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NS-1:0] irqIn,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic [NC-1:0] irqOut
);
  strobeT               strb;
  rdSelT                rdSel;
  logic [NC-1:0][NS-1:0] ctrlStatus;

  icDecode #(.AW(AW)) uDec (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  icCore #(.BW(BW), .NB(NB), .NC(NC), .DW(DW)) uCore (
    .clk        (clk),
    .rstN       (rstN),
    .irqIn      (irqIn),
    .strb       (strb),
    .rdSel      (rdSel),
    .wdata      (regWdata),
    .rdata      (regRdata),
    .ctrlStatus (ctrlStatus)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else
      for (int c = 0; c < NC; c++) irqOut[c] <= |ctrlStatus[c];
  end
endmodule

// File: rtl/icChecker.sv
module icChecker import icPkg::*; #(
  parameter int BW = BANK_W,
  parameter int NB = NBANK,
  parameter int NC = NCTRL,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int NS = BW * NB
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [AW-1:0]         regAddr,
  input logic [DW-1:0]         regWdata,
  input logic [DW-1:0]         regRdata,
  input logic [NC-1:0]         irqOut,
  input logic [NC-1:0][NS-1:0] ctrlStatus
);
  logic unmapped;
  always_comb begin
    if (int'(regAddr[AW-1:AW-2]) == TRIG_PAGE)
      unmapped = int'(regAddr[AW-3:0]) >= NB * TRIG_STRIDE;
    else
      unmapped = int'(regAddr[AW-3:0]) >= NB * CTRL_STRIDE;
  end

  // R1: outputs quiet while reset is applied
  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> irqOut == '0);

  // R2: unmapped offsets read as zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> regRdata == '0);

  // R8: clearing every enable of controller 0 low bank empties its status
  a_r8_enclr_all: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == AW'(CTRL_PAGE[0] * 256 + C_EN_CLR) && regWdata[BW-1:0] == '1)
    |=> ctrlStatus[0][BW-1:0] == '0);

  for (genvar c = 0; c < NC; c++) begin : gOut
    // R10: output rises only after a set status bit
    a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqOut[c]) |-> $past(ctrlStatus[c] != '0));
    // R10: output falls only after status emptied
    a_r10_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqOut[c]) |-> $past(ctrlStatus[c] == '0));
  end
endmodule

bind intcTrigger icChecker #(.BW(BW), .NB(NB), .NC(NC), .AW(AW), .DW(DW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .regRdata   (regRdata),
  .irqOut     (irqOut),
  .ctrlStatus (ctrlStatus)
);

// File: tb/sim_intcTrigger.sv
`timescale 1ns/1ps
module sim_intcTrigger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        regWe = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [2:0]  irqOut;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // bench model
  logic [63:0] mIn = '0, mRise = '0, mFall = '0, mLat = '0;
  logic [63:0] mEn [3] = '{default: '0};
  logic [63:0] mFrc [3] = '{default: '0};
  localparam int CBASE [3] = '{'h000, 'h100, 'h300};
  localparam int COFF [4] = '{'h08, 'h0C, 'h10, 'h14};
  localparam int TOFF [7] = '{'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C};

  always #4 clk = ~clk;

  intcTrigger u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [63:0] condV();
    logic [63:0] v;
    for (int i = 0; i < 64; i++)
      case ({mRise[i], mFall[i]})
        2'b00:   v[i] = mIn[i];
        2'b11:   v[i] = ~mIn[i];
        default: v[i] = mLat[i];
      endcase
    return v;
  endfunction

  function automatic logic [63:0] statV(int c);
    return (condV() | mFrc[c]) & mEn[c];
  endfunction

  function automatic logic [31:0] expCtrl(int c, int b, int off);
    logic [63:0] v;
    case (off)
      'h00: v = statV(c);
      'h04: v = condV() | mFrc[c];
      'h08, 'h0C: v = mEn[c];
      default: v = mFrc[c];
    endcase
    return v[b*32 +: 32];
  endfunction

  function automatic logic [31:0] expTrig(int b, int off);
    logic [63:0] v;
    case (off)
      'h00: v = condV();
      'h04: v = mLat;
      'h08, 'h10, 'h14: v = mRise;
      default: v = mFall;
    endcase
    return v[b*32 +: 32];
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrBus(int addr, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 10'(addr); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdBus(int addr, output logic [31:0] d);
    @(negedge clk);
    regAddr = 10'(addr);
    #1 d = regRdata;
  endtask

  task automatic wrCtrl(int c, int b, int off, logic [31:0] d);
    wrBus(CBASE[c] + b * 'h18 + off, d);
    case (off)
      'h08: mEn[c][b*32 +: 32]  = mEn[c][b*32 +: 32] | d;
      'h0C: mEn[c][b*32 +: 32]  = mEn[c][b*32 +: 32] & ~d;
      'h10: mFrc[c][b*32 +: 32] = mFrc[c][b*32 +: 32] | d;
      'h14: mFrc[c][b*32 +: 32] = mFrc[c][b*32 +: 32] & ~d;
      default: ;
    endcase
  endtask

  task automatic wrTrig(int b, int off, logic [31:0] d);
    wrBus('h200 + b * 'h20 + off, d);
    case (off)
      'h04: mLat[b*32 +: 32]  = mLat[b*32 +: 32] & ~d;
      'h08: mRise[b*32 +: 32] = d;
      'h0C: mFall[b*32 +: 32] = d;
      'h10: mRise[b*32 +: 32] = mRise[b*32 +: 32] | d;
      'h14: mRise[b*32 +: 32] = mRise[b*32 +: 32] & ~d;
      'h18: mFall[b*32 +: 32] = mFall[b*32 +: 32] | d;
      'h1C: mFall[b*32 +: 32] = mFall[b*32 +: 32] & ~d;
      default: ;
    endcase
    mLat = mLat & (mRise ^ mFall);
  endtask

  task automatic setIn(logic [63:0] nv);
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      if (mRise[i] && !mFall[i] && !mIn[i] && nv[i]) mLat[i] = 1'b1;
      if (!mRise[i] && mFall[i] && mIn[i] && !nv[i]) mLat[i] = 1'b1;
    end
    mIn = nv;
    irqIn = nv;
    repeat (4) @(negedge clk);
  endtask

  task automatic chkCtrl(string tag, int c, int b, int off);
    logic [31:0] d;
    rdBus(CBASE[c] + b * 'h18 + off, d);
    chk(tag, d, expCtrl(c, b, off));
  endtask

  task automatic chkTrig(string tag, int b, int off);
    logic [31:0] d;
    rdBus('h200 + b * 'h20 + off, d);
    chk(tag, d, expTrig(b, off));
  endtask

  task automatic chkIrq(string tag);
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < 3; c++) chk(tag, 32'(irqOut[c]), 32'(|statV(c)));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1c07));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irqOut), 32'h0);
    chkCtrl("R1 ctrl1 en", 1, 1, 'h08);
    chkCtrl("R1 ctrl2 frc", 2, 0, 'h10);
    chkTrig("R1 rise", 0, 'h08);
    chkTrig("R1 latch", 1, 'h04);

    // R2 map: ctrl2 bank1 at 0x318 range, other ctrl untouched, unmapped zero
    wrCtrl(2, 1, 'h08, 32'hA5A5_0F0F);
    chkCtrl("R2 ctrl2 hi en", 2, 1, 'h0C);
    chkCtrl("R2 ctrl0 hi en", 0, 1, 'h08);
    chkCtrl("R2 ctrl2 lo en", 2, 0, 'h08);
    rdBus('h030, d); chk("R2 unmapped ctrl", d, 32'h0);
    rdBus('h240, d); chk("R2 unmapped trig", d, 32'h0);
    wrCtrl(2, 1, 'h0C, 32'hFFFF_FFFF);

    // R3/R9 active-high level on line 5, controller 0
    wrCtrl(0, 0, 'h08, 32'h0000_0020);
    setIn(64'h20);
    chkCtrl("R9 raw lvl", 0, 0, 'h04);
    chkCtrl("R3 hi level stat", 0, 0, 'h00);
    chkIrq("R10 level irq");
    setIn(64'h0);
    chkCtrl("R7 level follows", 0, 0, 'h00);
    chkTrig("R7 no latch", 0, 'h04);
    chkIrq("R10 irq drop");

    // R3/R11 active-low on line 6
    wrTrig(0, 'h10, 32'h40);
    wrTrig(0, 'h18, 32'h40);
    chkTrig("R11 rise set", 0, 'h08);
    chkTrig("R11 fall set", 0, 'h0C);
    chkTrig("R3 low level", 0, 'h00);
    setIn(64'h40);
    chkTrig("R3 low level off", 0, 'h00);

    // R4 two-flop delay on line 40 (high bank, active-high)
    @(negedge clk); irqIn[40] = 1'b1; mIn[40] = 1'b1;
    rdBus('h220, d); chk("R4 after one edge", d & 32'h100, 32'h0);
    rdBus('h220, d); chk("R4 after two edges", d & 32'h100, 32'h100);

    // R10 output latency via soft force on controller 1
    wrCtrl(1, 0, 'h08, 32'h1);
    wrCtrl(1, 0, 'h10, 32'h1);
    chk("R10 still low", 32'(irqOut[1]), 32'h0);
    @(negedge clk);
    chk("R10 high next", 32'(irqOut[1]), 32'h1);
    chkCtrl("R9 forced raw", 1, 0, 'h04);
    wrCtrl(1, 0, 'h14, 32'h1);
    chkCtrl("R8 frc clr", 1, 0, 'h10);

    // R5 rising edge on line 10
    wrTrig(0, 'h10, 32'h400);
    setIn(mIn | 64'h400);
    setIn(mIn & ~64'h400);
    chkTrig("R5 latched", 0, 'h04);
    wrTrig(0, 'h04, 32'hFFFF_FBFF);
    chkTrig("R5 zero bits keep", 0, 'h04);
    wrTrig(0, 'h04, 32'h400);
    chkTrig("R5 ack clears", 0, 'h04);

    // R3 falling edge on line 11
    wrTrig(0, 'h18, 32'h800);
    setIn(mIn | 64'h800);
    chkTrig("R3 fall no event on rise", 0, 'h04);
    setIn(mIn & ~64'h800);
    chkTrig("R3 fall latched", 0, 'h04);

    // R6 edge in the same cycle as acknowledge on line 12
    wrTrig(0, 'h10, 32'h1000);
    setIn(mIn | 64'h1000);
    setIn(mIn & ~64'h1000);
    @(negedge clk); irqIn[12] = 1'b1; mIn[12] = 1'b1;
    @(negedge clk);
    wrBus('h204, 32'h1000);
    chkTrig("R6 relatched", 0, 'h04);
    wrTrig(0, 'h04, 32'h1000);
    chkTrig("R6 later ack clears", 0, 'h04);

    // R7 latched line moved to level mode loses latch
    setIn(mIn & ~64'h1000);
    setIn(mIn | 64'h1000);
    wrTrig(0, 'h14, 32'h1000);
    chkTrig("R7 mode clears latch", 0, 'h04);

    // R11 whole word write
    wrTrig(1, 'h0C, 32'h0F0F_00FF);
    chkTrig("R11 fall word", 1, 'h1C);
    wrTrig(1, 'h1C, 32'h0000_000F);
    chkTrig("R11 fall clr", 1, 'h0C);

    // R8 clear all enables of controller 0
    wrCtrl(0, 0, 'h0C, 32'hFFFF_FFFF);
    wrCtrl(0, 1, 'h0C, 32'hFFFF_FFFF);
    chkCtrl("R8 en cleared", 0, 0, 'h08);
    chkIrq("R8 irq after clear");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 3);
      int c  = $urandom_range(0, 2);
      int b  = $urandom_range(0, 1);
      logic [31:0] rd = $urandom & $urandom;
      case (op)
        0: setIn(mIn ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
        1: wrCtrl(c, b, COFF[$urandom_range(0, 3)], rd);
        2: wrTrig(b, TOFF[$urandom_range(0, 6)], rd);
        default: ;
      endcase
      if ($urandom_range(0, 1) == 0)
        chkCtrl("R9 random ctrl", c, b, $urandom_range(0, 5) * 4);
      else
        chkTrig("R11 random trig", b, $urandom_range(0, 7) * 4);
      chkIrq("R10 random irq");
    end

    finishRun();
  end
endmodule